// File: doc/BRIEF.md
# Synchronous Host Bus Register Slave

This block sits on a host processor's local bus as a synchronous slave and serves register reads and writes, plus two single-word DMA handshakes. Every host input is sampled on the rising edge of one bus clock. An access begins with a one-cycle, active-high address-latch pulse that is qualified by an active-low chip select. In the cycle that follows, the host either lowers the active-low write strobe to load a register or lowers the active-low output enable to read one. The read data bus is enabled only while chip select and output enable are both low. This is reported as a data-enable output that pads or a wrapper turn into a tri-state driver.

Behind the bus there are three things: a file of sixteen 32-bit registers, a DMA data register, and a command/status pair. Writing the command register raises a DMA write request, a DMA read request, or both. Each request stays high until its own active-low acknowledge is sampled low, and then exactly one word moves between the DMA data register and the bus. An output enable that arrives at any cycle other than the one right after the latch pulse sets a sticky protocol error bit. A DMA read handshake is the exception and does not set it.

Top module: `hbus_reg_slave`

## Requirements
- R1: A synchronous active-high reset clears all sixteen registers, the DMA data register and the error bit, deasserts both DMA requests and holds the data enable low even while chip select and output enable are low.
- R2: The address is captured only on a clock edge where the latch pulse is high and chip select is low. A latch pulse with chip select high captures nothing and opens no access.
- R3: A write loads the full 32-bit write data into the addressed location only when the write strobe and chip select are sampled low on the edge right after the latch pulse. A strobe sampled on any other edge changes nothing.
- R4: The address map is fixed. Addresses 0 to 15 select the register file, and 16 selects the DMA data register. Address 17 is the DMA command register: writing bit 0 = 1 raises the write request, writing bit 1 = 1 raises the read request, and reading it returns the write request in bit 0 and the read request in bit 1. Address 18 is the status register, with the error bit in bit 0. Any other address discards writes and reads as zero.
- R5: The data enable is high exactly while chip select and output enable are both low (outside reset). The data bus then carries the location selected by the latched address.
- R6: Output enable first sampled low, with chip select low, on an edge other than the one right after the latch pulse sets the sticky error bit. The data enable still follows the gating of R5. Writing 1 to bit 0 of the status register clears the bit.
- R7: The DMA write request stays high while its acknowledge is high. On the edge where the acknowledge is sampled low, the request falls and the write data bus is loaded into the DMA data register.
- R8: While the DMA read request is high and its acknowledge is low, the data bus carries the DMA data register regardless of the latched address. The request falls on that edge, and this output-enable use does not set the error bit.
- R9: An acknowledge sampled low while its own request is low has no effect: no request rises, and neither the DMA data register nor any other register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; all inputs sampled on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select, active low |
| ale_i | input | 1 | Address latch pulse, active high, one cycle |
| oe_n_i | input | 1 | Read output enable, active low |
| we_n_i | input | 1 | Write strobe, active low |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data bus |
| dack_wr_n_i | input | 1 | DMA write acknowledge, active low |
| dack_rd_n_i | input | 1 | DMA read acknowledge, active low |
| rdata_o | output | DATA_W | Read data bus value |
| rdata_oe_o | output | 1 | Read data bus drive enable |
| dreq_wr_o | output | 1 | DMA write request |
| dreq_rd_o | output | 1 | DMA read request |

## Verification
A wrong latched address or phase flag shows up in the same access. The write lands in the wrong place or is lost, and a read one cycle later returns the wrong word, or the status bit rises during a read that was legal. A stuck or early-dropping DMA request is visible on the request pins at the next edge. A DMA data register corrupted by a stray acknowledge shows on the next read of address 16. Reads of the command and status registers expose the request and error state through the bus alone, so every internal flip-flop that matters can be seen within two cycles of being disturbed.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    typedef enum logic [2:0] {
        SEL_REG   = 3'd0,
        SEL_DDATA = 3'd1,
        SEL_CMD   = 3'd2,
        SEL_STAT  = 3'd3,
        SEL_NONE  = 3'd4
    } sel_e;

    // Fixed map: file at 0..nreg-1, then DMA data, command, status.
    function automatic sel_e decode_sel(logic [31:0] a, logic [31:0] nreg);
        if (a < nreg)              return SEL_REG;
        else if (a == nreg)        return SEL_DDATA;
        else if (a == nreg + 32'd1) return SEL_CMD;
        else if (a == nreg + 32'd2) return SEL_STAT;
        else                       return SEL_NONE;
    endfunction

endpackage

// File: rtl/hbus_addr_phase.sv
module hbus_addr_phase #(
    parameter int ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cs_n_i,
    input  logic              ale_i,
    input  logic              oe_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              dma_rd_active_i,
    input  logic              clr_err_i,
    output logic [ADDR_W-1:0] addr_q_o,
    output logic              phase_q_o,
    output logic              err_q_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              phase;
        logic              oe_prev;
        logic              err;
    } ph_st_t;

    ph_st_t st_d, st_q;
    logic   latch;
    logic   oe_now;
    logic   oe_stray;

    always_comb begin
        st_d     = st_q;
        latch    = ale_i & ~cs_n_i;
        oe_now   = ~oe_n_i & ~cs_n_i;
        oe_stray = oe_now & ~st_q.oe_prev & ~st_q.phase & ~dma_rd_active_i;

        st_d.phase   = latch;
        st_d.oe_prev = oe_now;
        if (latch) begin
            st_d.addr = addr_i;
        end
        if (clr_err_i) begin
            st_d.err = 1'b0;
        end
        if (oe_stray) begin
            st_d.err = 1'b1;
        end
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign addr_q_o  = st_q.addr;
    assign phase_q_o = st_q.phase;
    assign err_q_o   = st_q.err;

    AST_PHASE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.phase && !ale_i |=> !st_q.phase); // R2
    AST_ALE_NO_CS: assert property (@(posedge clk_i) disable iff (rst_i)
        cs_n_i |=> !st_q.phase && $stable(st_q.addr)); // R2
    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.err && !clr_err_i |=> st_q.err); // R6
    AST_ERR_ON_STRAY_OE: assert property (@(posedge clk_i) disable iff (rst_i)
        !oe_n_i && !cs_n_i && !st_q.oe_prev && !st_q.phase && !dma_rd_active_i
        |=> st_q.err); // R6
    AST_ERR_RESET: assert property (@(posedge clk_i)
        rst_i |=> !st_q.err && !st_q.phase); // R1

endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile #(
    parameter int NREG   = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [DATA_W-1:0] ent_d [NREG];
    logic [DATA_W-1:0] ent_q [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_ent
        always_comb begin
            ent_d[k] = ent_q[k];
            if (wr_en_i && (wr_idx_i == IDX_W'(k))) begin
                ent_d[k] = wdata_i;
            end
            if (rst_i) begin
                ent_d[k] = '0;
            end
        end

        always_ff @(posedge clk_i) begin
            ent_q[k] <= ent_d[k];
        end

        AST_ENTRY_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
            !(wr_en_i && wr_idx_i == IDX_W'(k)) |=> $stable(ent_q[k])); // R3
    end

    assign rd_data_o = ent_q[rd_idx_i];

    AST_WRITE_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_en_i |=> ent_q[$past(wr_idx_i)] == $past(wdata_i)); // R3

endmodule

// File: rtl/hbus_dma_chan.sv
module hbus_dma_chan (
    input  logic clk_i,
    input  logic rst_i,
    input  logic set_i,
    input  logic ack_n_i,
    output logic req_o,
    output logic fire_o
);

    typedef struct packed {
        logic req;
    } dma_st_t;

    dma_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        fire_o = st_q.req & ~ack_n_i;
        if (fire_o) begin
            st_d.req = 1'b0;
        end
        if (set_i) begin
            st_d.req = 1'b1;
        end
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign req_o = st_q.req;

    AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.req && ack_n_i |=> st_q.req); // R7
    AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.req && !ack_n_i && !set_i |=> !st_q.req); // R8
    AST_ACK_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        !st_q.req && !set_i |=> !st_q.req); // R9
    AST_REQ_RESET: assert property (@(posedge clk_i)
        rst_i |=> !st_q.req); // R1

endmodule

// File: rtl/hbus_reg_slave.sv
module hbus_reg_slave
    import hbus_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int NREG   = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cs_n_i,
    input  logic              ale_i,
    input  logic              oe_n_i,
    input  logic              we_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              dack_wr_n_i,
    input  logic              dack_rd_n_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdata_oe_o,
    output logic              dreq_wr_o,
    output logic              dreq_rd_o
);

    localparam int IDX_W  = $clog2(NREG);
    localparam int NCHAN  = 2;
    localparam int CH_WR  = 0;
    localparam int CH_RD  = 1;

    typedef struct packed {
        logic [DATA_W-1:0] ddata;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [ADDR_W-1:0] addr_q;
    logic              phase_q;
    logic              err_q;
    logic              wr_cyc;
    sel_e              sel;
    logic [DATA_W-1:0] rf_rd;
    logic [NCHAN-1:0]  ch_set;
    logic [NCHAN-1:0]  ch_ack_n;
    logic [NCHAN-1:0]  ch_req;
    logic [NCHAN-1:0]  ch_fire;
    logic              clr_err;

    assign sel    = decode_sel(32'(addr_q), 32'(NREG));
    assign wr_cyc = phase_q & ~cs_n_i & ~we_n_i;

    always_comb begin
        ch_set          = '0;
        ch_set[CH_WR]   = wr_cyc && (sel == SEL_CMD) && wdata_i[0];
        ch_set[CH_RD]   = wr_cyc && (sel == SEL_CMD) && wdata_i[1];
        ch_ack_n        = '1;
        ch_ack_n[CH_WR] = dack_wr_n_i;
        ch_ack_n[CH_RD] = dack_rd_n_i;
        clr_err         = wr_cyc && (sel == SEL_STAT) && wdata_i[0];
    end

    hbus_addr_phase #(
        .ADDR_W (ADDR_W)
    ) u_phase (
        .clk_i           (clk_i),
        .rst_i           (rst_i),
        .cs_n_i          (cs_n_i),
        .ale_i           (ale_i),
        .oe_n_i          (oe_n_i),
        .addr_i          (addr_i),
        .dma_rd_active_i (ch_fire[CH_RD]),
        .clr_err_i       (clr_err),
        .addr_q_o        (addr_q),
        .phase_q_o       (phase_q),
        .err_q_o         (err_q)
    );

    hbus_regfile #(
        .NREG   (NREG),
        .DATA_W (DATA_W)
    ) u_rf (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_cyc && (sel == SEL_REG)),
        .wr_idx_i  (addr_q[IDX_W-1:0]),
        .wdata_i   (wdata_i),
        .rd_idx_i  (addr_q[IDX_W-1:0]),
        .rd_data_o (rf_rd)
    );

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        hbus_dma_chan u_chan (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .set_i   (ch_set[c]),
            .ack_n_i (ch_ack_n[c]),
            .req_o   (ch_req[c]),
            .fire_o  (ch_fire[c])
        );
    end

    // DMA data register: a write handshake outranks a bus write.
    always_comb begin
        st_d = st_q;
        if (ch_fire[CH_WR]) begin
            st_d.ddata = wdata_i;
        end else if (wr_cyc && (sel == SEL_DDATA)) begin
            st_d.ddata = wdata_i;
        end
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    // Read path: DMA read handshake overrides the latched address.
    always_comb begin
        rdata_o = '0;
        if (ch_fire[CH_RD]) begin
            rdata_o = st_q.ddata;
        end else begin
            case (sel)
                SEL_REG:   rdata_o = rf_rd;
                SEL_DDATA: rdata_o = st_q.ddata;
                SEL_CMD:   rdata_o = DATA_W'({ch_req[CH_RD], ch_req[CH_WR]});
                SEL_STAT:  rdata_o = DATA_W'(err_q);
                default:   rdata_o = '0;
            endcase
        end
    end

    assign rdata_oe_o = ~oe_n_i & ~cs_n_i & ~rst_i;
    assign dreq_wr_o  = ch_req[CH_WR];
    assign dreq_rd_o  = ch_req[CH_RD];

    AST_OE_NEEDS_CS: assert property (@(posedge clk_i)
        rdata_oe_o |-> !cs_n_i && !oe_n_i); // R5
    AST_OE_OFF_IN_RESET: assert property (@(posedge clk_i)
        rst_i |-> !rdata_oe_o); // R1
    AST_DDATA_CAPTURE: assert property (@(posedge clk_i) disable iff (rst_i)
        dreq_wr_o && !dack_wr_n_i |=> st_q.ddata == $past(wdata_i)); // R7
    AST_DMA_RD_DATA: assert property (@(posedge clk_i) disable iff (rst_i)
        dreq_rd_o && !dack_rd_n_i |-> rdata_o == st_q.ddata); // R8
    AST_DDATA_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        !dreq_wr_o && !(wr_cyc && sel == SEL_DDATA) |=> $stable(st_q.ddata)); // R9

endmodule

// File: tb/hbus_reg_slave_tb.sv
module hbus_reg_slave_tb;

    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NV = 13;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1;
    logic          ale = 1'b0;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          dack_wr_n = 1'b1;
    logic          dack_rd_n = 1'b1;
    logic [DW-1:0] rdata;
    logic          rdata_oe;
    logic          dreq_wr;
    logic          dreq_rd;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hbus_reg_slave u_dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .cs_n_i      (cs_n),
        .ale_i       (ale),
        .oe_n_i      (oe_n),
        .we_n_i      (we_n),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .dack_wr_n_i (dack_wr_n),
        .dack_rd_n_i (dack_rd_n),
        .rdata_o     (rdata),
        .rdata_oe_o  (rdata_oe),
        .dreq_wr_o   (dreq_wr),
        .dreq_rd_o   (dreq_rd)
    );

    // {is_write, address, data}; for reads data is the expected value
    localparam logic [40:0] VEC [NV] = '{
        {1'b1, 8'd0,   32'hA5A5_0001},
        {1'b1, 8'd5,   32'h1234_5678},
        {1'b1, 8'd15,  32'hFFFF_FFFF},
        {1'b1, 8'd19,  32'hDEAD_BEEF},
        {1'b1, 8'd16,  32'hCAFE_0016},
        {1'b0, 8'd0,   32'hA5A5_0001},
        {1'b0, 8'd5,   32'h1234_5678},
        {1'b0, 8'd15,  32'hFFFF_FFFF},
        {1'b0, 8'd3,   32'h0000_0000},
        {1'b0, 8'd19,  32'h0000_0000},
        {1'b0, 8'd16,  32'hCAFE_0016},
        {1'b0, 8'd18,  32'h0000_0000},
        {1'b0, 8'd200, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cs_n = 1'b0; ale = 1'b1; addr = a;
        @(negedge clk);
        ale = 1'b0; we_n = 1'b0; wdata = d;
        @(negedge clk);
        we_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic en);
        @(negedge clk);
        cs_n = 1'b0; ale = 1'b1; addr = a;
        @(negedge clk);
        ale = 1'b0; oe_n = 1'b0;
        #1;
        d  = rdata;
        en = rdata_oe;
        @(negedge clk);
        oe_n = 1'b1; cs_n = 1'b1;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic          en;

        // R1: reset holds enable low even with cs/oe asserted
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b0;
        #1;
        chk("R1 oe in reset", 32'(rdata_oe), 32'd0);
        @(negedge clk);
        cs_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 dreq_wr after reset", 32'(dreq_wr), 32'd0);
        chk("R1 dreq_rd after reset", 32'(dreq_rd), 32'd0);
        bus_read(8'd7, d, en);
        chk("R1 reg7 reset value", d, 32'd0);

        // Vector table: R3, R4, R5
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][40]) begin
                bus_write(VEC[i][39:32], VEC[i][31:0]);
            end else begin
                bus_read(VEC[i][39:32], d, en);
                chk("R4 read data", d, VEC[i][31:0]);
                chk("R5 data enable", 32'(en), 32'd1);
            end
        end

        // R5: output enable without chip select
        @(negedge clk);
        oe_n = 1'b0;
        #1;
        chk("R5 oe without cs", 32'(rdata_oe), 32'd0);
        @(negedge clk);
        oe_n = 1'b1;

        // R2: latch pulse without chip select opens no access
        @(negedge clk);
        ale = 1'b1; addr = 8'd8;
        @(negedge clk);
        ale = 1'b0; cs_n = 1'b0; we_n = 1'b0; wdata = 32'h0BAD_0008;
        @(negedge clk);
        we_n = 1'b1; cs_n = 1'b1;
        bus_read(8'd8, d, en);
        chk("R2 ale without cs", d, 32'd0);

        // R3: late write strobe ignored
        @(negedge clk);
        cs_n = 1'b0; ale = 1'b1; addr = 8'd7;
        @(negedge clk);
        ale = 1'b0;
        @(negedge clk);
        we_n = 1'b0; wdata = 32'h0BAD_0007;
        @(negedge clk);
        we_n = 1'b1; cs_n = 1'b1;
        bus_read(8'd7, d, en);
        chk("R3 late strobe ignored", d, 32'd0);

        // R6: late output enable sets error, enable still follows gating
        @(negedge clk);
        cs_n = 1'b0; ale = 1'b1; addr = 8'd5;
        @(negedge clk);
        ale = 1'b0;
        @(negedge clk);
        oe_n = 1'b0;
        #1;
        chk("R6 enable on late oe", 32'(rdata_oe), 32'd1);
        @(negedge clk);
        oe_n = 1'b1; cs_n = 1'b1;
        bus_read(8'd18, d, en);
        chk("R6 error set", d, 32'd1);
        bus_read(8'd18, d, en);
        chk("R6 error sticky", d, 32'd1);
        bus_write(8'd18, 32'd1);
        bus_read(8'd18, d, en);
        chk("R6 error cleared", d, 32'd0);

        // R7 + R9: DMA write handshake; stray read ack ignored
        bus_write(8'd17, 32'd1);
        chk("R7 wr request raised", 32'(dreq_wr), 32'd1);
        bus_read(8'd17, d, en);
        chk("R4 cmd readback", d, 32'd1);
        @(negedge clk);
        dack_rd_n = 1'b0;
        @(negedge clk);
        dack_rd_n = 1'b1;
        chk("R9 rd ack idle no request", 32'(dreq_rd), 32'd0);
        repeat (3) @(negedge clk);
        chk("R7 wr request held", 32'(dreq_wr), 32'd1);
        dack_wr_n = 1'b0; wdata = 32'h7777_1234;
        @(negedge clk);
        dack_wr_n = 1'b1;
        chk("R7 wr request dropped", 32'(dreq_wr), 32'd0);
        bus_read(8'd16, d, en);
        chk("R7 dma word captured", d, 32'h7777_1234);

        // R9: write ack with no request leaves DMA data alone
        @(negedge clk);
        dack_wr_n = 1'b0; wdata = 32'h0BAD_0016;
        @(negedge clk);
        dack_wr_n = 1'b1;
        chk("R9 no wr request raised", 32'(dreq_wr), 32'd0);
        bus_read(8'd16, d, en);
        chk("R9 dma data unchanged", d, 32'h7777_1234);

        // R8: DMA read handshake
        bus_write(8'd16, 32'h5151_AAAA);
        bus_write(8'd17, 32'd2);
        chk("R8 rd request raised", 32'(dreq_rd), 32'd1);
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b0; dack_rd_n = 1'b0;
        #1;
        chk("R8 dma read data", rdata, 32'h5151_AAAA);
        chk("R8 dma read enable", 32'(rdata_oe), 32'd1);
        @(negedge clk);
        cs_n = 1'b1; oe_n = 1'b1; dack_rd_n = 1'b1;
        chk("R8 rd request dropped", 32'(dreq_rd), 32'd0);
        bus_read(8'd18, d, en);
        chk("R8 no error from dma read", d, 32'd0);

        // R1: reset mid-run clears pending request and registers
        bus_write(8'd17, 32'd1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 request cleared", 32'(dreq_wr), 32'd0);
        bus_read(8'd5, d, en);
        chk("R1 reg5 cleared", d, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule